// File: doc/BRIEF.md
# I2C Target for a 16-bit Register Bank

This block is an I2C target that lets a bus controller read and write a bank of 16-bit registers through a 16-bit register pointer. The SCL and SDA lines are first synchronized and de-glitched in the system clock domain. A bit engine then decodes start, repeated start and stop conditions, compares the 7-bit device address and drives acknowledges. SDA is driven as open drain only: the block either pulls it low or releases it.

A write transaction sets the pointer from two bytes, high byte first. Any 16-bit data words that follow, also high byte first, are committed to the system side one register at a time, and the pointer steps after each word. A read starts with a write that sets the pointer. A repeated start with the read direction then returns words from the pointer onward until the controller answers a byte with a not-acknowledge. A later read transaction carries on from wherever the pointer was left, with no need to send the address again.

On the system side there is a single-cycle write strobe and a single-cycle read strobe. Both share one address bus. Read data is taken in the same cycle as the read strobe.

Top module: `i2c_reg16_target`

## Requirements
- R1: After reset, `sda_oe` is 0 (line released), and `reg_wr_en` and `reg_rd_en` are both 0.
- R2: The first byte after a start is the device address, MSB first. Bits 7..1 are compared with `DEV_ADDR`, and bit 0 is the direction (0 = write, 1 = read). On a match, the target pulls SDA low during the ninth clock.
- R3: When the device address does not match, SDA stays released on the ninth clock. No strobe is issued and the bus is ignored until the next start.
- R4: In a write transaction, the two bytes after the device address load the register pointer, high byte then low byte. Each of the two is acknowledged.
- R5: Every later pair of bytes forms one data word, high byte first. After the second byte's acknowledge clock ends, `reg_wr_en` pulses for one cycle, with `reg_addr` set to the pointer and `reg_wdata` set to the word.
- R6: The pointer advances by one after every committed write word and after every fetched read word. A burst of words therefore lands at n, n+1, n+2, and so on.
- R7: A read transaction returns the word at the pointer, high byte first and MSB first. The word is fetched with a one-cycle `reg_rd_en`, and `reg_rdata` is sampled in that same cycle.
- R8: While the controller acknowledges the low byte of a word, the next word is fetched and sent. A not-acknowledge ends the read: SDA is released and nothing more is fetched.
- R9: A new read transaction without an address phase continues from the word after the last one fetched.
- R10: `sda_oe` (1 = pull SDA low) rises only while the filtered SCL is low.
- R11: A stop returns the target to idle with SDA released. A start at any point restarts device address reception, and the pointer is kept.
- R12: A pulse on SDA or SCL shorter than `FILT_LEN` system cycles has no effect on the transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line as seen at the pad |
| sda_i | input | 1 | SDA line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_addr | output | 16 | Register address (current pointer) |
| reg_wdata | output | 16 | Register write data |
| reg_rdata | input | 16 | Register read data, valid while `reg_rd_en` is high |

## Verification
The bench targets the boundary between words inside a burst. It writes and reads four words in a row and then continues reading in a new transaction. A pointer that stepped per byte, did not step after a fetch, or fetched one word ahead on the final not-acknowledge would return shifted data at that point. A wrong device address must leave both the write strobe count and the stored value untouched; a target that acknowledged anyway would corrupt the register. A one-cycle SDA pulse while SCL is high would look like a start followed by a stop to an unfiltered target, which would drop the word being written.

// File: rtl/i2c_reg16_pkg.sv
package i2c_reg16_pkg;
   localparam int REG_AW = 16;
   localparam int REG_DW = 16;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RXACK,
      ST_TX,
      ST_TXACK
   } bus_state_e;

   typedef enum logic [2:0] {
      RL_DEV,
      RL_PHI,
      RL_PLO,
      RL_DHI,
      RL_DLO
   } rx_role_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 0) begin : g_bad_filt
      $error("FILT_LEN must not be negative");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
   end
   assign synced = sync_q[SYNC_STAGES-1];

   if (FILT_LEN == 0) begin : g_bypass
      assign dout = synced;
   end else begin : g_filter
      logic [CW-1:0] run_q;
      logic          out_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run_q <= '0;
            out_q <= 1'b1;
         end else if (synced == out_q) begin
            run_q <= '0;
         end else if (run_q == CW'(FILT_LEN - 1)) begin
            run_q <= '0;
            out_q <= synced;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
      assign dout = out_q;

      // R12: the output only ever moves to a level the synchronizer held
      a_r12_filter_follow: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(out_q) |-> (out_q == $past(synced)));
   end
endmodule

// File: rtl/i2c_reg_ptr.sv
module i2c_reg_ptr
   import i2c_reg16_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_hi,
   input  logic              ld_lo,
   input  logic [7:0]        byte_in,
   input  logic              step,
   output logic [REG_AW-1:0] ptr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr <= '0;
      else if (ld_hi) ptr[REG_AW-1:REG_AW-8] <= byte_in;
      else if (ld_lo) ptr[7:0] <= byte_in;
      else if (step)  ptr <= ptr + 1'b1;
   end

   // R6: each step moves the pointer by exactly one register
   a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ld_hi && !ld_lo) |=> (ptr == $past(ptr) + 1'b1));
endmodule

// File: rtl/i2c_reg16_target.sv
module i2c_reg16_target
   import i2c_reg16_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h2A,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic              reg_wr_en,
   output logic              reg_rd_en,
   output logic [REG_AW-1:0] reg_addr,
   output logic [REG_DW-1:0] reg_wdata,
   input  logic [REG_DW-1:0] reg_rdata
);
   if (REG_DW != 16) begin : g_bad_dw
      $error("data words are sent as two bytes");
   end

   logic scl_f, sda_f, scl_p, sda_p;
   logic scl_rise, scl_fall, start_c, stop_c;

   i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_flt (
      .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_f));
   i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_flt (
      .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_f));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_f;
         sda_p <= sda_f;
      end
   end

   assign scl_rise = scl_f & ~scl_p;
   assign scl_fall = ~scl_f & scl_p;
   assign start_c  = scl_f & scl_p & sda_p & ~sda_f;
   assign stop_c   = scl_f & scl_p & ~sda_p & sda_f;

   bus_state_e        state;
   rx_role_e          role;
   logic [3:0]        cnt;
   logic [7:0]        shreg, hi_byte, tx_byte;
   logic [REG_DW-1:0] txword, wdata_q;
   logic              rw_read, tx_lo, mack, wr_pend, oe_q, wr_q, rd_q;
   logic              rx_done, ld_hi, ld_lo;

   assign rx_done = (state == ST_RX) && scl_fall && (cnt == 4'd8) && !start_c && !stop_c;
   assign ld_hi   = rx_done && (role == RL_PHI);
   assign ld_lo   = rx_done && (role == RL_PLO);
   assign tx_byte = tx_lo ? txword[7:0] : txword[15:8];

   i2c_reg_ptr u_ptr (
      .clk(clk), .rst_n(rst_n), .ld_hi(ld_hi), .ld_lo(ld_lo),
      .byte_in(shreg), .step(wr_q | rd_q), .ptr(reg_addr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         role    <= RL_DEV;
         cnt     <= '0;
         shreg   <= '0;
         hi_byte <= '0;
         txword  <= '0;
         wdata_q <= '0;
         rw_read <= 1'b0;
         tx_lo   <= 1'b0;
         mack    <= 1'b0;
         wr_pend <= 1'b0;
         oe_q    <= 1'b0;
         wr_q    <= 1'b0;
         rd_q    <= 1'b0;
      end else begin
         wr_q <= 1'b0;
         rd_q <= 1'b0;
         if (rd_q) txword <= reg_rdata;
         if (start_c) begin
            state   <= ST_RX;
            role    <= RL_DEV;
            cnt     <= '0;
            oe_q    <= 1'b0;
            wr_pend <= 1'b0;
         end else if (stop_c) begin
            state   <= ST_IDLE;
            oe_q    <= 1'b0;
            wr_pend <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: ;
               ST_RX: begin
                  if (scl_rise && cnt != 4'd8) begin
                     shreg <= {shreg[6:0], sda_f};
                     cnt   <= cnt + 4'd1;
                  end else if (rx_done) begin
                     cnt   <= '0;
                     oe_q  <= 1'b1;
                     state <= ST_RXACK;
                     unique case (role)
                        RL_DEV: begin
                           if (shreg[7:1] == DEV_ADDR) begin
                              rw_read <= shreg[0];
                              if (shreg[0]) begin
                                 rd_q  <= 1'b1;
                                 tx_lo <= 1'b0;
                              end else begin
                                 role <= RL_PHI;
                              end
                           end else begin
                              oe_q  <= 1'b0;
                              state <= ST_IDLE;
                           end
                        end
                        RL_PHI: role <= RL_PLO;
                        RL_PLO: role <= RL_DHI;
                        RL_DHI: begin
                           hi_byte <= shreg;
                           role    <= RL_DLO;
                        end
                        RL_DLO: begin
                           wdata_q <= {hi_byte, shreg};
                           wr_pend <= 1'b1;
                           role    <= RL_DHI;
                        end
                        default: role <= RL_DEV;
                     endcase
                  end
               end
               ST_RXACK: begin
                  if (scl_fall) begin
                     if (wr_pend) begin
                        wr_q    <= 1'b1;
                        wr_pend <= 1'b0;
                     end
                     if (rw_read) begin
                        state <= ST_TX;
                        oe_q  <= ~txword[15];
                        cnt   <= 4'd1;
                     end else begin
                        state <= ST_RX;
                        oe_q  <= 1'b0;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (cnt == 4'd8) begin
                        oe_q  <= 1'b0;
                        state <= ST_TXACK;
                     end else begin
                        oe_q <= ~tx_byte[3'd7 - cnt[2:0]];
                        cnt  <= cnt + 4'd1;
                     end
                  end
               end
               ST_TXACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_f;
                     if (!sda_f && tx_lo) rd_q <= 1'b1;
                  end else if (scl_fall) begin
                     if (mack) begin
                        tx_lo <= ~tx_lo;
                        state <= ST_TX;
                        cnt   <= 4'd1;
                        oe_q  <= tx_lo ? ~txword[15] : ~txword[7];
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign sda_oe    = oe_q;
   assign reg_wr_en = wr_q;
   assign reg_rd_en = rd_q;
   assign reg_wdata = wdata_q;

   // R10: the line is only pulled low while the filtered clock is low
   a_r10_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> !scl_f);
   // R5: a write strobe lasts a single cycle
   a_r5_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |=> !wr_q);
   // R7: fetch and commit never share a cycle on the address bus
   a_r7_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_q && rd_q));
   // R11: an idle target holds SDA released
   a_r11_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !oe_q);
endmodule

// File: tb/i2c_reg16_target_tb.sv
module i2c_reg16_target_tb;
   localparam int Q = 10;
   localparam int H = 20;
   localparam logic [6:0] DEV = 7'h2A;
   localparam logic [31:0] VEC [6] = '{
      32'h0001_1234, 32'h1202_FFFF, 32'h0303_0000,
      32'hFF04_8001, 32'h0005_5AA5, 32'h8006_00FF};

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n, scl_m, sda_m_low;
   logic        sda_oe, reg_wr_en, reg_rd_en;
   logic [15:0] reg_addr, reg_wdata, reg_rdata;
   logic        sda_line;
   logic [15:0] sysmem [16];
   logic [15:0] expmem [16];
   int          checks = 0, fails = 0, wr_cnt = 0, rd_cnt = 0, r10_bad = 0;
   logic        oe_prev = 1'b0;

   assign sda_line  = ~(sda_m_low | sda_oe);
   assign reg_rdata = sysmem[reg_addr[3:0]];

   i2c_reg16_target #(.DEV_ADDR(DEV)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
      .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

   always @(posedge clk) begin
      if (reg_wr_en) begin
         sysmem[reg_addr[3:0]] <= reg_wdata;
         wr_cnt <= wr_cnt + 1;
      end
      if (reg_rd_en) rd_cnt <= rd_cnt + 1;
      if (rst_n && sda_oe && !oe_prev && scl_m) r10_bad <= r10_bad + 1;
      oe_prev <= sda_oe;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m_low = 1'b0; wt(Q);
      scl_m = 1'b1;     wt(H);
      sda_m_low = 1'b1; wt(H);
      scl_m = 1'b0;     wt(Q);
   endtask

   task automatic bus_stop();
      sda_m_low = 1'b1; wt(Q);
      scl_m = 1'b1;     wt(H);
      sda_m_low = 1'b0; wt(H);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m_low = ~b[i]; wt(Q);
         scl_m = 1'b1;
         if (glitch && b[i]) begin
            wt(H/2); sda_m_low = 1'b1; wt(1); sda_m_low = 1'b0; wt(H/2 - 1);
         end else begin
            wt(H);
         end
         scl_m = 1'b0; wt(Q);
      end
      sda_m_low = 1'b0; wt(Q);
      scl_m = 1'b1; wt(H/2);
      ack = ~sda_line;
      wt(H/2);
      scl_m = 1'b0; wt(Q);
   endtask

   task automatic recv_byte(input bit nack, output logic [7:0] b);
      sda_m_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         wt(Q);
         scl_m = 1'b1; wt(H/2);
         b[i] = sda_line;
         wt(H/2);
         scl_m = 1'b0; wt(Q);
      end
      sda_m_low = ~nack; wt(Q);
      scl_m = 1'b1; wt(H);
      scl_m = 1'b0; wt(Q);
      sda_m_low = 1'b0;
   endtask

   task automatic wr_txn(input logic [6:0] dev, input logic [15:0] addr, input logic [15:0] wd [4],
                         input int n, input bit glitch, output bit dev_ack, output bit all_ack);
      bit a;
      bus_start();
      send_byte({dev, 1'b0}, 1'b0, dev_ack);
      all_ack = dev_ack;
      if (dev_ack) begin
         send_byte(addr[15:8], 1'b0, a); all_ack &= a;
         send_byte(addr[7:0], 1'b0, a);  all_ack &= a;
         for (int k = 0; k < n; k++) begin
            send_byte(wd[k][15:8], glitch, a); all_ack &= a;
            send_byte(wd[k][7:0], 1'b0, a);    all_ack &= a;
         end
      end
      bus_stop();
   endtask

   task automatic rd_words(input int n, output logic [15:0] rd [4], output bit ack);
      logic [7:0] hb, lb;
      send_byte({DEV, 1'b1}, 1'b0, ack);
      for (int k = 0; k < n; k++) begin
         recv_byte(1'b0, hb);
         recv_byte(k == n - 1, lb);
         rd[k] = {hb, lb};
      end
      bus_stop();
   endtask

   task automatic rd_txn(input logic [15:0] addr, input int n, output logic [15:0] rd [4], output bit ack);
      bit a1, a2, a3, a4;
      bus_start();
      send_byte({DEV, 1'b0}, 1'b0, a1);
      send_byte(addr[15:8], 1'b0, a2);
      send_byte(addr[7:0], 1'b0, a3);
      bus_start();
      rd_words(n, rd, a4);
      ack = a1 & a2 & a3 & a4;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      wt(190000);
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      summary();
   end

   initial begin
      logic [15:0] wd [4];
      logic [15:0] rd [4];
      bit          dack, aack;
      int          base_wr, base_rd;
      for (int i = 0; i < 16; i++) begin
         sysmem[i] = 16'hA5A5 ^ (16'(i) * 16'h1111);
         expmem[i] = 16'hA5A5 ^ (16'(i) * 16'h1111);
      end
      for (int i = 0; i < 4; i++) begin
         wd[i] = '0;
         rd[i] = '0;
      end
      scl_m = 1'b1; sda_m_low = 1'b0; rst_n = 1'b0;
      wt(5);
      // R1: released line and quiet strobes in reset and just after it
      chk(!sda_oe && !reg_wr_en && !reg_rd_en, "R1", {29'd0, sda_oe, reg_wr_en, reg_rd_en}, 32'd0);
      rst_n = 1'b1;
      wt(20);
      chk(!sda_oe && !reg_wr_en && !reg_rd_en, "R1", {29'd0, sda_oe, reg_wr_en, reg_rd_en}, 32'd0);

      // R2 R4 R5 R7: single word write then read back, table driven
      foreach (VEC[v]) begin
         wd[0] = VEC[v][15:0];
         base_wr = wr_cnt;
         wr_txn(DEV, VEC[v][31:16], wd, 1, 1'b0, dack, aack);
         expmem[VEC[v][19:16]] = VEC[v][15:0];
         chk(aack && (wr_cnt == base_wr + 1), "R2 R4 R5 ack and one commit",
             {aack, 31'(wr_cnt - base_wr)}, {1'b1, 31'd1});
         rd_txn(VEC[v][31:16], 1, rd, aack);
         chk(aack && rd[0] == expmem[VEC[v][19:16]], "R7 read back", {15'd0, aack, rd[0]},
             {15'd0, 1'b1, expmem[VEC[v][19:16]]});
      end

      // R6: burst write of four words from 0x0008
      wd[0] = 16'h1111; wd[1] = 16'h2222; wd[2] = 16'h4444; wd[3] = 16'h8888;
      base_wr = wr_cnt;
      wr_txn(DEV, 16'h0008, wd, 4, 1'b0, dack, aack);
      for (int k = 0; k < 4; k++) expmem[8 + k] = wd[k];
      chk(aack && wr_cnt == base_wr + 4, "R6 burst commits", 32'(wr_cnt - base_wr), 32'd4);

      // R8: burst read of four words, ending on a not-acknowledge
      base_rd = rd_cnt;
      rd_txn(16'h0008, 4, rd, aack);
      for (int k = 0; k < 4; k++)
         chk(rd[k] == expmem[8 + k], "R8 R6 burst read word", {16'd0, rd[k]}, {16'd0, expmem[8 + k]});
      chk(rd_cnt == base_rd + 4 && !sda_oe, "R8 no fetch after nack", 32'(rd_cnt - base_rd), 32'd4);

      // R9: continuing read with no address phase picks up at 0x000C
      bus_start();
      rd_words(2, rd, aack);
      chk(aack && rd[0] == expmem[12], "R9 continue first", {16'd0, rd[0]}, {16'd0, expmem[12]});
      chk(rd[1] == expmem[13], "R9 continue second", {16'd0, rd[1]}, {16'd0, expmem[13]});

      // R3: wrong device address, no acknowledge, register left alone
      wd[0] = 16'hDEAD;
      base_wr = wr_cnt;
      wr_txn(DEV ^ 7'h01, 16'h0001, wd, 1, 1'b0, dack, aack);
      chk(!dack && wr_cnt == base_wr, "R3 ignored", {dack, 31'(wr_cnt - base_wr)}, 32'd0);
      rd_txn(16'h0001, 1, rd, aack);
      chk(rd[0] == expmem[1], "R3 R11 value kept", {16'd0, rd[0]}, {16'd0, expmem[1]});

      // R12: one-cycle SDA pulse while SCL is high must not break the write
      wd[0] = 16'hF00F;
      wr_txn(DEV, 16'h000E, wd, 1, 1'b1, dack, aack);
      expmem[14] = 16'hF00F;
      rd_txn(16'h000E, 1, rd, aack);
      chk(rd[0] == expmem[14], "R12 glitch filtered", {16'd0, rd[0]}, {16'd0, expmem[14]});

      // R10 R11: pulled low only with SCL low, released once idle
      chk(r10_bad == 0, "R10 open drain timing", 32'(r10_bad), 32'd0);
      chk(!sda_oe, "R11 idle release", {31'd0, sda_oe}, 32'd0);
      summary();
   end
endmodule